// File: doc/BRIEF.md
# Shared Ready-Strobe and Serial-Data Output Pin

This block drives one output pin that does two jobs. It signals that a new conversion result is ready, and it then carries that 24-bit two's-complement result to a host, one bit at a time. A result-valid strobe hands a word to the block. A fixed schedule of phases then runs. First a load phase, with the pin high. Then a short low pulse, then a high interval. Then a data window in which host serial clock falling edges step through the word from the most significant bit downward. The sequence ends with a closing phase in which the pin is back in ready mode.

The host serial clock is asynchronous to the system clock, which runs the block. A two-flop synchronizer and an edge detector bring the host clock in, so the host clock period must be at least four system clock periods. Each phase length is a parameter in system clock cycles. A word that arrives while a sequence runs is held. It starts a new sequence as soon as the block returns to waiting.

Top module: `ready_data_port`

## Requirements
- R1: Out of reset and while waiting for a result, the pin is high (ready mode, no pending word).
- R2: When the strobe is sampled at clock edge k with the block waiting, the load phase starts at edge k+1. The pin is then high for T1_CYC cycles, low for T2_CYC cycles and high for T3_CYC cycles, after which the data window of DATA_CYC cycles begins.
- R3: With no host clock falling edges in the data window, the pin shows bit 23 (the sign bit) of the word for the whole window.
- R4: After k falling edges of the host clock in the data window, with k from 1 to 23, the pin shows bit 23-k of the word. The pin changes at most three system clock cycles after the edge and at no other time.
- R5: After 24 or more falling edges in the data window, the pin is low until the window ends.
- R6: After the data window the pin is high for T4_CYC cycles (closing phase), and then the block waits with the pin high.
- R7: The bit pointer is cleared at the start of the load phase and at the start of the closing phase, so every read begins at bit 23 of the newest loaded word.
- R8: A strobe that arrives during a sequence is held, and a later strobe overwrites the held word. The held word starts its load phase one cycle after the block starts waiting. A strobe in the cycle a held word is taken into the load phase stays held for the sequence after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sclk | input | 1 | Host serial clock, asynchronous, idle low |
| result_vld | input | 1 | One-cycle strobe marking a new result |
| result_word | input | WORD_W | Two's-complement result, taken when result_vld is high |
| rdy_dout | output | 1 | Shared ready-strobe / serial data pin |

## Verification
Two functions can fall in the same clock cycle. One is a new strobe landing in the hold register. The other is the held word being taken into the load phase. The bench provokes this by strobing a third word in the cycle right after the block returns to waiting, while a second word is still held. It judges the result by checking that the second word is read in full next, and that the third word then gets a complete sequence of its own. Read lengths of zero, 23, 24 and over 24 clocks are mixed with random words and random lengths, and each bit is compared with a value taken from the word.

// File: rtl/rdp_pkg.sv
// Package: phase encoding shared by the output-port sequencer, shifter and checker.
package rdp_pkg;
    typedef enum logic [2:0] {
        PH_WAIT  = 3'd0,   // waiting for a result, pin high
        PH_LOAD  = 3'd1,   // result being loaded, pin high
        PH_LOW   = 3'd2,   // ready pulse, pin low
        PH_HIGH  = 3'd3,   // ready pulse tail, pin high
        PH_DATA  = 3'd4,   // serial data window
        PH_CLOSE = 3'd5    // closing interval, pin high
    } phase_e;
endpackage

// File: rtl/rdp_sclk_sync.sv
// Module: rdp_sclk_sync
// Brings the asynchronous host serial clock into the system clock domain
// through two flops and flags each falling edge for one cycle.
// Assumes the host clock stays in each level for at least two system cycles.
module rdp_sclk_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_async,
    output logic fall_o
);
    logic meta_q, sync_q, last_q;

    // Two-stage synchronizer plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= sclk_async;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    // Falling edge: previous synchronized level high, current low.
    always_comb fall_o = last_q & ~sync_q;
endmodule

// File: rtl/rdp_sequencer.sv
// Module: rdp_sequencer
// Runs the fixed phase schedule and holds an incoming result until the block
// is waiting. Assumes every phase length parameter is at least 1.
module rdp_sequencer
    import rdp_pkg::*;
#(
    parameter int W        = 24,
    parameter int T1_CYC   = 4,
    parameter int T2_CYC   = 3,
    parameter int T3_CYC   = 3,
    parameter int DATA_CYC = 400,
    parameter int T4_CYC   = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] word_i,
    output phase_e       phase_o,
    output logic         take_o,
    output logic         close_go_o,
    output logic [W-1:0] held_word_o
);
    localparam int M12  = (T1_CYC > T2_CYC) ? T1_CYC : T2_CYC;
    localparam int M34  = (T3_CYC > T4_CYC) ? T3_CYC : T4_CYC;
    localparam int M4   = (M12 > M34) ? M12 : M34;
    localparam int MAXP = (M4 > DATA_CYC) ? M4 : DATA_CYC;
    localparam int TW   = $clog2(MAXP + 1);

    phase_e         phase_q;
    logic [TW-1:0]  timer_q;
    logic           held_v_q;
    logic [W-1:0]   held_w_q;
    logic           timer_done;

    always_comb begin
        timer_done = (timer_q == '0);
        take_o     = (phase_q == PH_WAIT) && held_v_q;
        close_go_o = (phase_q == PH_DATA) && timer_done;
        phase_o    = phase_q;
        held_word_o = held_w_q;
    end

    // Hold register: newest strobe wins; cleared when taken unless refilled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v_q <= 1'b0;
            held_w_q <= '0;
        end else if (vld_i) begin
            held_v_q <= 1'b1;
            held_w_q <= word_i;
        end else if (take_o) begin
            held_v_q <= 1'b0;
        end
    end

    // Phase state and down-counting phase timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_WAIT;
            timer_q <= '0;
        end else begin
            case (phase_q)
                PH_WAIT: if (held_v_q) begin
                    phase_q <= PH_LOAD;
                    timer_q <= TW'(T1_CYC - 1);
                end
                PH_LOAD: if (timer_done) begin
                    phase_q <= PH_LOW;
                    timer_q <= TW'(T2_CYC - 1);
                end else timer_q <= timer_q - 1'b1;
                PH_LOW: if (timer_done) begin
                    phase_q <= PH_HIGH;
                    timer_q <= TW'(T3_CYC - 1);
                end else timer_q <= timer_q - 1'b1;
                PH_HIGH: if (timer_done) begin
                    phase_q <= PH_DATA;
                    timer_q <= TW'(DATA_CYC - 1);
                end else timer_q <= timer_q - 1'b1;
                PH_DATA: if (timer_done) begin
                    phase_q <= PH_CLOSE;
                    timer_q <= TW'(T4_CYC - 1);
                end else timer_q <= timer_q - 1'b1;
                PH_CLOSE: if (timer_done) begin
                    phase_q <= PH_WAIT;
                    timer_q <= '0;
                end else timer_q <= timer_q - 1'b1;
                default: begin
                    phase_q <= PH_WAIT;
                    timer_q <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/rdp_shifter.sv
// Module: rdp_shifter
// Holds the word being read and a saturating bit pointer; shifts one bit per
// synchronized host falling edge in the data window and drives the pin.
// Assumes the sequencer pulses take_o/close_go_o for one cycle each.
module rdp_shifter
    import rdp_pkg::*;
#(
    parameter int W  = 24,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase_i,
    input  logic          take_i,
    input  logic          close_go_i,
    input  logic          fall_i,
    input  logic [W-1:0]  word_i,
    output logic [CW-1:0] cnt_o,
    output logic          pin_o
);
    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    // Load on take, clear pointer at close, shift on falling edge in data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (take_i) begin
            sh_q  <= word_i;
            cnt_q <= '0;
        end else if (close_go_i) begin
            cnt_q <= '0;
        end else if ((phase_i == PH_DATA) && fall_i) begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            if (cnt_q != CW'(W)) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Pin level: current top bit in data mode, low pulse in PH_LOW, else high.
    always_comb begin
        cnt_o = cnt_q;
        if (phase_i == PH_DATA) pin_o = sh_q[W-1];
        else                    pin_o = (phase_i != PH_LOW);
    end
endmodule

// File: rtl/ready_data_port.sv
// Module: ready_data_port
// Top level of the shared ready/data output pin: synchronizer, phase
// sequencer and output shifter. Assumes host clock period >= 4 system cycles.
module ready_data_port
    import rdp_pkg::*;
#(
    parameter int WORD_W   = 24,
    parameter int T1_CYC   = 4,
    parameter int T2_CYC   = 3,
    parameter int T3_CYC   = 3,
    parameter int DATA_CYC = 400,
    parameter int T4_CYC   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sclk,
    input  logic              result_vld,
    input  logic [WORD_W-1:0] result_word,
    output logic              rdy_dout
);
    localparam int CW = $clog2(WORD_W + 1);

    phase_e            phase;
    logic              take;
    logic              close_go;
    logic              sclk_fall;
    logic [WORD_W-1:0] held_word;
    logic [CW-1:0]     bit_cnt;

    rdp_sclk_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_async (host_sclk),
        .fall_o     (sclk_fall)
    );

    rdp_sequencer #(
        .W(WORD_W), .T1_CYC(T1_CYC), .T2_CYC(T2_CYC),
        .T3_CYC(T3_CYC), .DATA_CYC(DATA_CYC), .T4_CYC(T4_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .vld_i       (result_vld),
        .word_i      (result_word),
        .phase_o     (phase),
        .take_o      (take),
        .close_go_o  (close_go),
        .held_word_o (held_word)
    );

    rdp_shifter #(.W(WORD_W), .CW(CW)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .take_i     (take),
        .close_go_i (close_go),
        .fall_i     (sclk_fall),
        .word_i     (held_word),
        .cnt_o      (bit_cnt),
        .pin_o      (rdy_dout)
    );
endmodule

// File: rtl/rdp_checker.sv
// Module: rdp_checker
// Property checks on the shared output pin, bound into ready_data_port.
module rdp_checker
    import rdp_pkg::*;
#(
    parameter int W  = 24,
    parameter int CW = $clog2(W + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input phase_e        phase,
    input logic [CW-1:0] cnt,
    input logic          fall,
    input logic          pin
);
    AST_WAIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT) |-> pin);                                     // R1
    AST_LOW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW) |-> !pin);                                     // R2
    AST_LOW_TO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW) |=> (phase == PH_LOW || phase == PH_HIGH));    // R2
    AST_PTR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && !fall) |=> (cnt == $past(cnt) || phase != PH_DATA)); // R4
    AST_OVERLONG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && cnt == CW'(W)) |-> !pin);                   // R5
    AST_CLOSE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CLOSE) |-> pin);                                    // R6
    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOAD || phase == PH_CLOSE) |-> (cnt == '0));       // R7
endmodule

bind ready_data_port rdp_checker #(.W(WORD_W), .CW(CW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase),
    .cnt   (bit_cnt),
    .fall  (sclk_fall),
    .pin   (rdy_dout)
);

// File: tb/ready_data_port_bench.sv
// Bench: directed corner reads plus seeded random reads on ready_data_port.
module ready_data_port_bench;
    localparam int W  = 24;
    localparam int T1 = 4;
    localparam int T2 = 3;
    localparam int T3 = 3;
    localparam int DC = 400;
    localparam int T4 = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_sclk = 1'b0;
    logic         result_vld = 1'b0;
    logic [W-1:0] result_word = '0;
    logic         rdy_dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ready_data_port #(.WORD_W(W), .T1_CYC(T1), .T2_CYC(T2), .T3_CYC(T3),
                      .DATA_CYC(DC), .T4_CYC(T4)) u_ready_data_port (
        .clk(clk), .rst_n(rst_n), .host_sclk(host_sclk),
        .result_vld(result_vld), .result_word(result_word), .rdy_dout(rdy_dout)
    );

    // Expected pin level after k falling edges in the data window.
    function automatic logic exp_bit(input logic [W-1:0] w, input int k);
        if (k < W) return w[W-1-k];
        return 1'b0;
    endfunction

    task automatic chk(input logic exp, input string req, input string what);
        checks++;
        if (rdy_dout !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, rdy_dout, exp);
        end
    endtask

    task automatic strobe(input logic [W-1:0] w);
        @(negedge clk);
        result_vld  = 1'b1;
        result_word = w;
    endtask

    // One full sequence; from_pend means the word is already held and taken
    // at the next edge. n host clocks are given; optional strobes mid-window.
    task automatic run_seq(input logic [W-1:0] w, input int n, input bit from_pend,
                           input bit do_pend, input logic [W-1:0] p1,
                           input logic [W-1:0] p2);
        int used;
        @(negedge clk);
        result_vld = 1'b0;
        if (!from_pend) @(negedge clk);
        chk(1'b1, "R2", "load phase high");
        repeat (T1) @(negedge clk);
        chk(1'b0, "R2", "ready low pulse");
        repeat (T2) @(negedge clk);
        chk(1'b1, "R2", "ready high tail");
        repeat (T3) @(negedge clk);
        chk(exp_bit(w, 0), "R7", "first data bit is MSB");
        used = 0;
        if (do_pend) begin
            result_vld = 1'b1; result_word = p1;
            @(negedge clk);
            result_word = p2;
            @(negedge clk);
            result_vld = 1'b0;
            used = 2;
            chk(exp_bit(w, 0), "R8", "strobe mid-read leaves pin alone");
        end
        for (int k = 1; k <= n; k++) begin
            host_sclk = 1'b1;
            repeat (4) @(negedge clk);
            chk(exp_bit(w, k - 1), "R4", "pin steady on rising host edge");
            host_sclk = 1'b0;
            repeat (4) @(negedge clk);
            used += 8;
            chk(exp_bit(w, k), (k < W) ? "R4" : "R5", "bit after falling edge");
        end
        repeat (DC - 1 - used) @(negedge clk);
        chk(exp_bit(w, n), (n == 0) ? "R3" : ((n < W) ? "R4" : "R5"),
            "level held to end of window");
        @(negedge clk);
        chk(1'b1, "R6", "closing phase high");
        repeat (T4) @(negedge clk);
        chk(1'b1, "R6", "waiting high after close");
    endtask

    initial begin
        logic [W-1:0] a, b, c, d;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(1'b1, "R1", "pin during reset");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(1'b1, "R1", "pin idle after reset");

        // R3: no clocks, negative and positive words.
        strobe(24'h912345); run_seq(24'h912345, 0, 0, 0, '0, '0);
        strobe(24'h2ABCDE); run_seq(24'h2ABCDE, 0, 0, 0, '0, '0);
        // R4/R5 boundaries: 23, 24, 25 and 30 clocks.
        strobe(24'hA5C3F0); run_seq(24'hA5C3F0, 23, 0, 0, '0, '0);
        strobe(24'h7FFFFF); run_seq(24'h7FFFFF, 24, 0, 0, '0, '0);
        strobe(24'hFFFFFF); run_seq(24'hFFFFFF, 25, 0, 0, '0, '0);
        strobe(24'h800001); run_seq(24'h800001, 30, 0, 0, '0, '0);

        // R8 chain: B overwritten by D while A is read; C strobed as D is taken.
        a = 24'h13579B; b = 24'hFEDCBA; d = 24'h5A5A5A; c = 24'hC0FFEE;
        strobe(a); run_seq(a, 5, 0, 1, b, d);
        result_vld = 1'b1; result_word = c;
        run_seq(d, 24, 1, 0, '0, '0);
        run_seq(c, 3, 1, 0, '0, '0);
        repeat (3) @(negedge clk);
        chk(1'b1, "R1", "waiting after chain with nothing held");

        // Random reads, R4/R7 with random words and lengths.
        for (int i = 0; i < 12; i++) begin
            a = W'($urandom);
            strobe(a);
            run_seq(a, $urandom_range(0, 30), 0, 0, '0, '0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule